// File: doc/BRIEF.md
# Legacy Low-Memory Range Router

This block sits in the address decode path of a memory controller hub. It examines each request address below 1 MB. Two legacy windows get special handling: the video window at A0000h–BFFFFh and the expansion-ROM window at C0000h–DFFFFh. For each request it chooses where the request goes: system DRAM, one of `N_PORTS` downstream I/O ports, the default legacy bridge port, or nowhere. "Nowhere" means the request is left for subtractive decode.

The video window can be claimed by one downstream port through that port's video-enable bit. If no port claims it, the window goes to the bridge. An SMM region overlays the same addresses. A processor request that carries the SMM-memory message bit, while SMM space is enabled, goes to DRAM. Every other request to the window stays with the video owner. The ROM window is cut into eight 16 KB segments, and each segment carries a 2-bit access attribute. Requests that the attribute permits go to DRAM. All other requests are left unclaimed.

The decision is registered once. The response appears one clock after the request strobe and holds until the next request.

Top module: `lowmem_router`

## Requirements
- R1: A request whose address lies in A0000h–BFFFFh (address bits above bit 16 equal 5) reports `rsp_hit`=1 and `rsp_cacheable`=0.
- R2: A video-window request with `vga_en`=0 that is not routed to DRAM by R4 reports `rsp_dest`=3 (bridge) and `rsp_port`=0.
- R3: A video-window request not routed to DRAM by R4, with at least one `vga_en` bit set, reports `rsp_dest`=2 (port) and `rsp_port` = index of the lowest set `vga_en` bit.
- R4: A video-window request with `smm_enable`=1, `req_from_cpu`=1 and `req_smm_mem`=1 reports `rsp_dest`=1 (DRAM) and `rsp_port`=0.
- R5: A processor video-window request with `smm_enable`=1 and `req_smm_mem`=0 goes to the video owner (port per R3, else bridge), never DRAM.
- R6: A video-window request with `req_from_cpu`=0 never reports `rsp_dest`=1, whatever `req_smm_mem` and `smm_enable` are.
- R7: Addresses B0000h–B7FFFh are routed exactly like the rest of the video window.
- R8: In C0000h–DFFFFh the segment index is address bits [16:14], and its attribute is `rom_attr[2*idx+1:2*idx]`. The encodings are 00 disabled, 01 read-only, 10 write-only and 11 read/write. A permitted access reports `rsp_dest`=1, `rsp_hit`=1 and `rsp_cacheable`=1.
- R9: A ROM-window access whose type the segment attribute does not permit, including any access to a disabled segment, reports `rsp_dest`=0, `rsp_hit`=0 and `rsp_cacheable`=0.
- R10: Any address outside both windows, including those at or above 1 MB, reports `rsp_dest`=0, `rsp_hit`=0, `rsp_cacheable`=0 and `rsp_port`=0.
- R11: `rsp_valid` follows `req_valid` by exactly one clock. While `req_valid`=0, every other output holds its value.
- R12: `rsp_misroute` is 1 for a request exactly when more than one `vga_en` bit was set at request time.
- R13: After reset, `rsp_valid`, `rsp_dest`, `rsp_port`, `rsp_hit`, `rsp_cacheable` and `rsp_misroute` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_from_cpu | input | 1 | 1 = processor request, 0 = downstream port or bridge request |
| req_smm_mem | input | 1 | SMM-memory message bit of the request |
| vga_en | input | N_PORTS | Per-port video-window claim bits |
| smm_enable | input | 1 | Enables the SMM overlay of the video window |
| rom_attr | input | 16 | Eight 2-bit ROM segment attributes, segment 0 in the low bits |
| rsp_valid | output | 1 | Response valid, one clock after `req_valid` |
| rsp_dest | output | 2 | 0 unclaimed, 1 DRAM, 2 downstream port, 3 bridge |
| rsp_port | output | $clog2(N_PORTS) | Downstream port index when `rsp_dest`=2, else 0 |
| rsp_cacheable | output | 1 | Destination may be cached |
| rsp_hit | output | 1 | Request was positively claimed |
| rsp_misroute | output | 1 | More than one port claimed the video window |

## Verification
The properties relate the request-side inputs in a strobe cycle to the response one clock later. They therefore assume that every input is known whenever `req_valid` is high. They also assume that no request is issued during the two clocks the internal reset takes to release after `rst_n` rises. The bench drives every input to a defined value from the first cycle and holds `req_valid` low for several clocks after reset. Configuration inputs change only in cycles where the bench is about to issue a fresh request, so each response depends only on what was present at its strobe.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [1:0] {
    DST_NONE   = 2'd0,
    DST_DRAM   = 2'd1,
    DST_PORT   = 2'd2,
    DST_BRIDGE = 2'd3
  } dest_e;

  localparam int WIN_LSB     = 17;  // 128 KB window granularity
  localparam int VIDEO_TAG   = 5;   // A0000h..BFFFFh
  localparam int ROM_TAG     = 6;   // C0000h..DFFFFh
  localparam int SEG_LSB     = 14;  // 16 KB segments
  localparam int ROM_SEGS    = 8;
  localparam int SEG_W       = $clog2(ROM_SEGS);
  localparam int ATTR_W      = 2;
  localparam int ATTR_RD_BIT = 0;
  localparam int ATTR_WR_BIT = 1;
  localparam int ROM_ATTR_W  = ROM_SEGS * ATTR_W;
endpackage

// File: rtl/lmr_reset_sync.sv
module lmr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lmr_lowest_pick.sv
module lmr_lowest_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic             multi
);
  always_comb begin
    any   = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    multi = ($countones(req) > 1);
  end
endmodule

// File: rtl/lmr_rom_decode.sv
module lmr_rom_decode
  import lmr_pkg::*;
(
  input  logic [SEG_W-1:0]      seg_idx,
  input  logic                  is_write,
  input  logic [ROM_ATTR_W-1:0] rom_attr,
  output logic                  allow
);
  logic [ATTR_W-1:0] seg_attr [ROM_SEGS];
  logic [ATTR_W-1:0] sel_attr;

  for (genvar s = 0; s < ROM_SEGS; s++) begin : g_seg
    assign seg_attr[s] = rom_attr[s*ATTR_W +: ATTR_W];
  end

  assign sel_attr = seg_attr[seg_idx];
  assign allow    = is_write ? sel_attr[ATTR_WR_BIT] : sel_attr[ATTR_RD_BIT];
endmodule

// File: rtl/lmr_video_decode.sv
module lmr_video_decode
  import lmr_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              smm_enable,
  input  logic              from_cpu,
  input  logic              smm_mem,
  input  logic              owner_any,
  input  logic [PORT_W-1:0] owner_idx,
  output dest_e             dest,
  output logic [PORT_W-1:0] port
);
  logic smm_to_dram;

  assign smm_to_dram = smm_enable & from_cpu & smm_mem;

  always_comb begin
    dest = DST_BRIDGE;
    port = '0;
    if (smm_to_dram) begin
      dest = DST_DRAM;
    end else if (owner_any) begin
      dest = DST_PORT;
      port = owner_idx;
    end
  end
endmodule

// File: rtl/lowmem_router.sv
module lowmem_router
  import lmr_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 32,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic                  req_from_cpu,
  input  logic                  req_smm_mem,
  input  logic [N_PORTS-1:0]    vga_en,
  input  logic                  smm_enable,
  input  logic [ROM_ATTR_W-1:0] rom_attr,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_dest,
  output logic [PORT_W-1:0]     rsp_port,
  output logic                  rsp_cacheable,
  output logic                  rsp_hit,
  output logic                  rsp_misroute
);
  localparam int HI_W = ADDR_W - WIN_LSB;

  logic              rst_n_int;
  logic [HI_W-1:0]   win_tag;
  logic              in_video, in_rom;
  logic              owner_any, owner_multi;
  logic [PORT_W-1:0] owner_idx;
  dest_e             vid_dest;
  logic [PORT_W-1:0] vid_port;
  logic              rom_allow;

  dest_e             nxt_dest;
  logic [PORT_W-1:0] nxt_port;
  logic              nxt_cache, nxt_hit;

  dest_e             dest_q;
  logic [PORT_W-1:0] port_q;
  logic              valid_q, cache_q, hit_q, mis_q;

  lmr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign win_tag  = req_addr[ADDR_W-1:WIN_LSB];
  assign in_video = (win_tag == HI_W'(VIDEO_TAG));
  assign in_rom   = (win_tag == HI_W'(ROM_TAG));

  lmr_lowest_pick #(.N(N_PORTS), .IDX_W(PORT_W)) u_pick (
    .req   (vga_en),
    .any   (owner_any),
    .idx   (owner_idx),
    .multi (owner_multi)
  );

  lmr_video_decode #(.PORT_W(PORT_W)) u_video (
    .smm_enable (smm_enable),
    .from_cpu   (req_from_cpu),
    .smm_mem    (req_smm_mem),
    .owner_any  (owner_any),
    .owner_idx  (owner_idx),
    .dest       (vid_dest),
    .port       (vid_port)
  );

  lmr_rom_decode u_rom (
    .seg_idx  (req_addr[SEG_LSB +: SEG_W]),
    .is_write (req_write),
    .rom_attr (rom_attr),
    .allow    (rom_allow)
  );

  // next-state selection
  always_comb begin
    nxt_dest  = DST_NONE;
    nxt_port  = '0;
    nxt_cache = 1'b0;
    nxt_hit   = 1'b0;
    if (in_video) begin
      nxt_dest = vid_dest;
      nxt_port = vid_port;
      nxt_hit  = 1'b1;
    end else if (in_rom && rom_allow) begin
      nxt_dest  = DST_DRAM;
      nxt_cache = 1'b1;
      nxt_hit   = 1'b1;
    end
  end

  // response registers, loaded on request strobe
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      dest_q  <= DST_NONE;
      port_q  <= '0;
      cache_q <= 1'b0;
      hit_q   <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        dest_q  <= nxt_dest;
        port_q  <= nxt_port;
        cache_q <= nxt_cache;
        hit_q   <= nxt_hit;
        mis_q   <= owner_multi;
      end
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_dest      = dest_q;
  assign rsp_port      = port_q;
  assign rsp_cacheable = cache_q;
  assign rsp_hit       = hit_q;
  assign rsp_misroute  = mis_q;
endmodule

// File: rtl/lowmem_router_chk.sv
module lowmem_router_chk #(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_write,
  input logic                req_from_cpu,
  input logic                req_smm_mem,
  input logic [N_PORTS-1:0]  vga_en,
  input logic                smm_enable,
  input logic [15:0]         rom_attr,
  input logic                rsp_valid,
  input logic [1:0]          rsp_dest,
  input logic [PORT_W-1:0]   rsp_port,
  input logic                rsp_cacheable,
  input logic                rsp_hit,
  input logic                rsp_misroute
);
  logic       vid, rom, smm_hit;
  logic [1:0] seg_attr;

  assign vid      = (req_addr >> 17) == ADDR_W'(5);
  assign rom      = (req_addr >> 17) == ADDR_W'(6);
  assign smm_hit  = smm_enable && req_from_cpu && req_smm_mem;
  assign seg_attr = rom_attr[{req_addr[16:14], 1'b0} +: 2];

  AST_VIDEO_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid |=> rsp_hit && !rsp_cacheable); // R1

  AST_VIDEO_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid && !smm_hit && (vga_en == '0) |=> rsp_dest == 2'd3); // R2

  AST_VIDEO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid && !smm_hit && (vga_en != '0) |=> rsp_dest == 2'd2); // R3

  AST_SMM_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid && smm_hit |=> rsp_dest == 2'd1 && rsp_port == '0); // R4

  AST_SMM_OFF_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid && req_from_cpu && !req_smm_mem |=> rsp_dest != 2'd1); // R5

  AST_DOWNSTREAM_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vid && !req_from_cpu |=> rsp_dest != 2'd1); // R6

  AST_ROM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rom && (seg_attr == 2'b00) |=> rsp_dest == 2'd0 && !rsp_hit); // R9

  AST_ROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rom && seg_attr[req_write] |=> rsp_dest == 2'd1 && rsp_cacheable); // R8

  AST_OUTSIDE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !vid && !rom |=> rsp_dest == 2'd0 && !rsp_hit && !rsp_cacheable); // R10

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_dest) && $stable(rsp_port) && $stable(rsp_hit)); // R11

  AST_MISROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_misroute == ($countones($past(vga_en)) > 1)); // R12
endmodule

bind lowmem_router lowmem_router_chk #(
  .N_PORTS (N_PORTS),
  .ADDR_W  (ADDR_W),
  .PORT_W  (PORT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_write     (req_write),
  .req_from_cpu  (req_from_cpu),
  .req_smm_mem   (req_smm_mem),
  .vga_en        (vga_en),
  .smm_enable    (smm_enable),
  .rom_attr      (rom_attr),
  .rsp_valid     (rsp_valid),
  .rsp_dest      (rsp_dest),
  .rsp_port      (rsp_port),
  .rsp_cacheable (rsp_cacheable),
  .rsp_hit       (rsp_hit),
  .rsp_misroute  (rsp_misroute)
);

// File: tb/lowmem_router_tb_top.sv
`timescale 1ns/100ps
module lowmem_router_tb_top;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, req_from_cpu, req_smm_mem, smm_enable;
  logic [AW-1:0] req_addr;
  logic [NP-1:0] vga_en;
  logic [15:0]   rom_attr;
  logic          rsp_valid, rsp_cacheable, rsp_hit, rsp_misroute;
  logic [1:0]    rsp_dest;
  logic [PW-1:0] rsp_port;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  int e_valid = 0, e_dest = 0, e_port = 0, e_cache = 0, e_hit = 0, e_mis = 0;

  always #2.5 clk = ~clk;

  lowmem_router #(.N_PORTS(NP), .ADDR_W(AW)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
    .req_write (req_write), .req_from_cpu (req_from_cpu), .req_smm_mem (req_smm_mem),
    .vga_en (vga_en), .smm_enable (smm_enable), .rom_attr (rom_attr),
    .rsp_valid (rsp_valid), .rsp_dest (rsp_dest), .rsp_port (rsp_port),
    .rsp_cacheable (rsp_cacheable), .rsp_hit (rsp_hit), .rsp_misroute (rsp_misroute)
  );

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "valid", int'(rsp_valid), e_valid);
    chk(tag, "dest",  int'(rsp_dest), e_dest);
    chk(tag, "port",  int'(rsp_port), e_port);
    chk(tag, "cache", int'(rsp_cacheable), e_cache);
    chk(tag, "hit",   int'(rsp_hit), e_hit);
    chk(tag, "mis",   int'(rsp_misroute), e_mis);
  endtask

  // behavioural model of one request
  task automatic model(input longint a, input bit w, input bit cpu, input bit sm);
    int cnt = 0;
    e_dest = 0; e_port = 0; e_cache = 0; e_hit = 0;
    for (int i = 0; i < NP; i++) if (vga_en[i]) cnt++;
    e_mis = (cnt > 1) ? 1 : 0;
    if (a >= 'hA0000 && a < 'hC0000) begin
      e_hit = 1;
      if (smm_enable && cpu && sm) e_dest = 1;
      else if (cnt > 0) begin
        e_dest = 2;
        for (int i = NP - 1; i >= 0; i--) if (vga_en[i]) e_port = i;
      end else e_dest = 3;
    end else if (a >= 'hC0000 && a < 'hE0000) begin
      int s  = int'((a - 'hC0000) / 16384);
      int at = int'((rom_attr >> (2 * s)) & 16'h3);
      bit ok = w ? (at == 2 || at == 3) : (at == 1 || at == 3);
      if (ok) begin e_dest = 1; e_hit = 1; e_cache = 1; end
    end
  endtask

  task automatic step(input bit v, input longint a, input bit w, input bit cpu,
                      input bit sm, input string tag);
    req_valid = v; req_addr = AW'(a); req_write = w;
    req_from_cpu = cpu; req_smm_mem = sm;
    @(posedge clk); #1;
    e_valid = v ? 1 : 0;
    if (v) model(a, w, cpu, sm);
    compare_all(tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_write = 0;
    req_from_cpu = 1; req_smm_mem = 0; vga_en = '0; smm_enable = 0; rom_attr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    compare_all("R13");

    // R10: outside both windows
    step(1, 'h00000, 0, 1, 0, "R10");
    step(1, 'h9FFFF, 1, 1, 0, "R10");
    step(1, 'hE0000, 0, 1, 0, "R10");
    step(1, 'h10A000, 0, 1, 0, "R10");

    // R2 / R1: bridge default
    step(1, 'hA0000, 0, 1, 0, "R2");
    step(1, 'hBFFFF, 1, 0, 0, "R1");
    // R7: monochrome range
    step(1, 'hB0000, 0, 1, 0, "R7");
    vga_en = 4'b0100;
    step(1, 'hB7FFF, 1, 1, 0, "R7");
    // R3 and R12
    vga_en = 4'b0010;
    step(1, 'hA8000, 0, 1, 0, "R3");
    vga_en = 4'b1010;
    step(1, 'hA8000, 0, 1, 0, "R12");
    vga_en = 4'b1000;
    step(1, 'hA0010, 1, 0, 0, "R3");

    // R4 / R5 / R6 SMM overlay
    smm_enable = 1; vga_en = 4'b0001;
    step(1, 'hA4000, 0, 1, 1, "R4");
    step(1, 'hA4000, 1, 1, 0, "R5");
    vga_en = '0;
    step(1, 'hB4000, 0, 1, 0, "R5");
    step(1, 'hB4000, 0, 0, 1, "R6");
    vga_en = 4'b0100;
    step(1, 'hA2000, 1, 0, 1, "R6");
    smm_enable = 0;
    step(1, 'hA2000, 0, 1, 1, "R4");

    // R11: idle cycles hold outputs despite input changes
    step(0, 'hC0000, 1, 1, 0, "R11");
    step(0, 'h00000, 0, 0, 1, "R11");

    // R8 / R9: ROM segment attributes (seg7..seg0 = 00,10,01,11,00,01,10,11)
    rom_attr = 16'b00_10_01_11_00_01_10_11;
    for (int s = 0; s < 8; s++) begin
      step(1, 'hC0000 + s * 'h4000 + 'h123, 0, 1, 0, "R8");
      step(1, 'hC0000 + s * 'h4000 + 'h3FF0, 1, 1, 0, "R9");
    end
    rom_attr = '0;
    step(1, 'hD8000, 0, 1, 0, "R9");
    step(1, 'hC4000, 1, 1, 0, "R9");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      longint a;
      int r = $urandom_range(0, 9);
      if (r < 4)      a = 'hA0000 + $urandom_range(0, 'h1FFFF);
      else if (r < 7) a = 'hC0000 + $urandom_range(0, 'h1FFFF);
      else if (r < 9) a = $urandom_range(0, 'hFFFFF);
      else            a = 'h100000 + $urandom_range(0, 'hFFFF);
      vga_en     = NP'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0) vga_en = '0;
      smm_enable = 1'($urandom_range(0, 1));
      rom_attr   = 16'($urandom_range(0, 65535));
      step(1'($urandom_range(0, 4) != 0), a, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R11");
    end

    summary();
    $finish;
  end
endmodule